// File: doc/BRIEF.md
# Coarse/Fine Time-to-Digital Encoder

This block is the digital back end of a per-pixel time-to-digital converter. A detector hit opens a measurement. On the first rising clock edge that sees the hit, the block freezes the state of an external delay chain. The chain reaches it as a thermometer vector, and the block turns it into a 4-bit fine value. From then on a saturating coarse counter advances once per clock edge. A stop pulse, which is synchronous with the clock, closes the interval. No fine interpolation is needed at the stop end, because the stop is already aligned to the clock. The coarse and fine parts are packed into one 10-bit code, which is held with a valid flag until the next acquisition clear.

A mode input turns the block into a plain photon counter. In that mode the coarse counter advances on every hit instead of on every clock edge, and the fine field reads zero. Each acquisition window begins with a clear pulse, and only the first hit after that clear is timed. The top entry of the delay chain is a load-matching dummy and has no effect on the result.

Top module: `tdc_pixel_encoder`

## Requirements
- R1: After `rst_n` low or an `acq_clr` pulse, `code` is 0 and `code_valid` is 0.
- R2: In timing mode (`count_mode`=0), the first edge in a frame where `hit` is high captures `taps`. At the stop edge, `code[3:0]` holds the number of ones in `taps[14:0]` as captured (0 to 15).
- R3: `taps[15]` is a dummy. Its value never changes `code`.
- R4: A bubble in the thermometer vector (a 0 below a 1) is resolved by counting ones, not by finding the first zero.
- R5: In timing mode, `code[9:4]` equals the number of rising edges after the capture edge, up to and including the edge that samples `stop` high. `code_valid` rises at that stop edge.
- R6: A `stop` with no earlier `hit` in the frame leaves `code` at 0 and `code_valid` at 0. Hits after it are ignored until `acq_clr`.
- R7: Once the capture edge has passed, further hits and any change on `taps` do not alter the result.
- R8: The coarse field saturates at 63 and does not wrap.
- R9: With `count_mode`=1, `code[9:4]` equals the number of edges with `hit` high from the frame clear through the stop edge, inclusive. `code[3:0]` is 0 and `code_valid` is 1, even when the count is 0.
- R10: After `code_valid` rises, `code` and `code_valid` hold through further `stop` and `hit` pulses until `acq_clr`.
- R11: In timing mode, `hit` and `stop` on the same edge give a coarse field of 0, the fine value of that edge's `taps`, and `code_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast measurement clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_clr | input | 1 | Clears the result and re-arms for a new frame |
| count_mode | input | 1 | 0 = timing, 1 = photon counting |
| hit | input | 1 | Detector pulse, one per clock cycle at most |
| taps | input | 16 | Delay-chain thermometer snapshot; bit 15 is a dummy |
| stop | input | 1 | Clock-synchronous end of the interval |
| code | output | 10 | {coarse[5:0], fine[3:0]} |
| code_valid | output | 1 | High while `code` holds a real measurement |

## Verification
The bench builds the block with its defaults: 16 taps and a 6-bit coarse field. This puts the dummy at bit 15, so its influence can be probed directly. It also means a gap of 63 or more edges reaches counter saturation within a short frame. Fine values cover the full 0 to 15 span, including a bubble pattern. Photon counting is run with zero hits and with a hit that coincides with the stop. Counting past 63 hits covers saturation in that mode.

// File: rtl/tdc_enc_pkg.sv
// Shared types for the coarse/fine TDC encoder.
package tdc_enc_pkg;

    // Measurement phase inside one acquisition frame.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

endpackage

// File: rtl/tdc_therm_count.sv
// Fine encoder: counts the ones among the live taps of the delay-chain
// snapshot. Counting ones makes a single bubble harmless.
// Assumes TAPS is a power of two. The top tap is a dummy and is not counted.
module tdc_therm_count #(
    parameter int TAPS   = 16,
    parameter int FINE_W = $clog2(TAPS)
) (
    input  logic [TAPS-2:0]   live_taps,
    output logic [FINE_W-1:0] fine
);
    localparam int LIVE = TAPS - 1;

    logic [FINE_W-1:0] part [0:LIVE];

    // Running sum through the chain, one adder stage per live tap.
    assign part[0] = '0;
    for (genvar i = 0; i < LIVE; i++) begin : g_sum
        assign part[i+1] = part[i] + FINE_W'(live_taps[i]);
    end

    assign fine = part[LIVE];
endmodule

// File: rtl/tdc_sat_counter.sv
// Coarse counter: synchronous clear, conditional increment, and a hold at
// the all-ones value. Exposes the next value so that a result can be
// latched on the same edge that performs the last increment.
module tdc_sat_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nx
);
    localparam logic [W-1:0] TOP = '1;

    // Next value: clear wins, otherwise increment unless already saturated.
    always_comb begin
        if (clr)
            cnt_nx = '0;
        else if (inc && (cnt_q != TOP))
            cnt_nx = cnt_q + W'(1);
        else
            cnt_nx = cnt_q;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/tdc_frame_ctrl.sv
// Frame controller: arms on clear, captures the fine value at the first hit,
// closes on stop, and holds the packed result until the next clear.
// In counting mode the RUN phase is skipped and hits feed the counter.
// Assumes count_mode stays constant within a frame.
module tdc_frame_ctrl
    import tdc_enc_pkg::*;
#(
    parameter int COARSE_W = 6,
    parameter int FINE_W   = 4,
    parameter int CODE_W   = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acq_clr,
    input  logic                count_mode,
    input  logic                hit,
    input  logic                stop,
    input  logic [FINE_W-1:0]   fine_now,
    input  logic [COARSE_W-1:0] cnt_nx,
    output logic                cnt_clr,
    output logic                cnt_inc,
    output logic [CODE_W-1:0]   code_q,
    output logic                valid_q
);
    phase_e            phase_q;
    logic [FINE_W-1:0] fine_q;

    // Counter control: restart on frame clear or at the timing capture edge.
    always_comb begin
        cnt_clr = acq_clr || (!count_mode && (phase_q == PH_IDLE) && hit);
        if (count_mode)
            cnt_inc = hit && (phase_q != PH_DONE);
        else
            cnt_inc = (phase_q == PH_RUN);
    end

    // Phase, captured fine value and held result.
    always_ff @(posedge clk) begin
        if (!rst_n || acq_clr) begin
            phase_q <= PH_IDLE;
            fine_q  <= '0;
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (count_mode) begin
                        if (stop) begin
                            code_q  <= {cnt_nx, FINE_W'(0)};
                            valid_q <= 1'b1;
                            phase_q <= PH_DONE;
                        end
                    end else if (hit && stop) begin
                        code_q  <= {COARSE_W'(0), fine_now};
                        valid_q <= 1'b1;
                        phase_q <= PH_DONE;
                    end else if (hit) begin
                        fine_q  <= fine_now;
                        phase_q <= PH_RUN;
                    end else if (stop) begin
                        phase_q <= PH_DONE;
                    end
                end
                PH_RUN: begin
                    if (stop) begin
                        code_q  <= {cnt_nx, fine_q};
                        valid_q <= 1'b1;
                        phase_q <= PH_DONE;
                    end
                end
                default: begin
                    phase_q <= PH_DONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/tdc_pixel_encoder.sv
// Top of the coarse/fine TDC encoder. Ties together the fine thermometer
// counter, the saturating coarse counter and the frame controller.
// Assumes hit and stop are already synchronous to clk, and that taps is
// stable at the edge where the hit is first seen.
module tdc_pixel_encoder #(
    parameter int TAPS     = 16,
    parameter int COARSE_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 acq_clr,
    input  logic                                 count_mode,
    input  logic                                 hit,
    input  logic [TAPS-1:0]                      taps,
    input  logic                                 stop,
    output logic [COARSE_W+$clog2(TAPS)-1:0]     code,
    output logic                                 code_valid
);
    localparam int FINE_W = $clog2(TAPS);
    localparam int CODE_W = COARSE_W + FINE_W;

    logic [FINE_W-1:0]   fine_now;
    logic [COARSE_W-1:0] cnt_q;
    logic [COARSE_W-1:0] cnt_nx;
    logic                cnt_clr;
    logic                cnt_inc;
    logic                dummy_tap_unused;
    logic [COARSE_W-1:0] cnt_q_unused;

    // The top tap only balances the load on the chain.
    assign dummy_tap_unused = taps[TAPS-1];
    assign cnt_q_unused     = cnt_q;

    tdc_therm_count #(
        .TAPS   (TAPS),
        .FINE_W (FINE_W)
    ) u_fine (
        .live_taps (taps[TAPS-2:0]),
        .fine      (fine_now)
    );

    tdc_sat_counter #(
        .W (COARSE_W)
    ) u_coarse (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .cnt_q  (cnt_q),
        .cnt_nx (cnt_nx)
    );

    tdc_frame_ctrl #(
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W),
        .CODE_W   (CODE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_clr    (acq_clr),
        .count_mode (count_mode),
        .hit        (hit),
        .stop       (stop),
        .fine_now   (fine_now),
        .cnt_nx     (cnt_nx),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .code_q     (code),
        .valid_q    (code_valid)
    );
endmodule

// File: rtl/tdc_pixel_encoder_chk.sv
// Temporal checks on the encoder's ports, bound into every instance.
module tdc_pixel_encoder_chk #(
    parameter int CODE_W = 10,
    parameter int FINE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acq_clr,
    input logic              count_mode,
    input logic              stop,
    input logic [CODE_W-1:0] code,
    input logic              code_valid
);
    // A clear empties the result on the following cycle.
    p_clear_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acq_clr |=> (!code_valid && (code == '0)));

    // A held result stays put until a clear arrives.
    p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !acq_clr) |=> (code_valid && $stable(code)));

    // Without a valid measurement the code reads as the no-event value.
    p_no_event_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> (code == '0));

    // A result only appears on the edge after a stop was sampled.
    p_valid_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> $past(stop));

    // Counting-mode results carry an empty fine field.
    p_count_fine_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(code_valid) && $past(count_mode)) |-> (code[FINE_W-1:0] == '0));
endmodule

bind tdc_pixel_encoder tdc_pixel_encoder_chk #(
    .CODE_W (CODE_W),
    .FINE_W (FINE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_clr    (acq_clr),
    .count_mode (count_mode),
    .stop       (stop),
    .code       (code),
    .code_valid (code_valid)
);

// File: tb/sim_tdc_pixel_encoder.sv
module sim_tdc_pixel_encoder;
    logic        clk        = 1'b0;
    logic        rst_n      = 1'b0;
    logic        acq_clr    = 1'b0;
    logic        count_mode = 1'b0;
    logic        hit        = 1'b0;
    logic [15:0] taps       = 16'h0000;
    logic        stop       = 1'b0;
    logic [9:0]  code;
    logic        code_valid;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    tdc_pixel_encoder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_clr    (acq_clr),
        .count_mode (count_mode),
        .hit        (hit),
        .taps       (taps),
        .stop       (stop),
        .code       (code),
        .code_valid (code_valid)
    );

    // 250 MHz
    always #2 clk = ~clk;

    typedef struct packed {
        logic        mode;
        logic [15:0] t;
        logic [7:0]  n;
    } vec_t;

    // n = stop gap in timing mode, number of hits in counting mode
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 8'd1},
        '{1'b0, 16'h7FFF, 8'd5},
        '{1'b0, 16'h8000, 8'd3},
        '{1'b0, 16'hFFFF, 8'd9},
        '{1'b0, 16'h002F, 8'd12},
        '{1'b0, 16'h0F0F, 8'd63},
        '{1'b0, 16'h0155, 8'd70},
        '{1'b1, 16'h0000, 8'd3},
        '{1'b1, 16'h0000, 8'd0},
        '{1'b1, 16'hFFFF, 8'd5}
    };

    function automatic logic [3:0] ones15(input logic [15:0] t);
        logic [3:0] s = '0;
        for (int i = 0; i < 15; i++) s += {3'b0, t[i]};
        return s;
    endfunction

    function automatic logic [5:0] sat63(input int n);
        return (n > 63) ? 6'd63 : n[5:0];
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic clear_frame();
        @(negedge clk); acq_clr = 1'b1;
        @(negedge clk); acq_clr = 1'b0;
    endtask

    task automatic frame_time(input logic [15:0] t, input int gap);
        count_mode = 1'b0;
        clear_frame();
        @(negedge clk); hit = 1'b1; taps = t;
        @(negedge clk); hit = 1'b0; taps = ~t;   // later changes are ignored (R7)
        repeat (gap - 1) @(negedge clk);
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic frame_count(input logic [15:0] t, input int nh);
        count_mode = 1'b1;
        taps = t;
        clear_frame();
        for (int i = 0; i < nh; i++) begin
            hit = 1'b1; @(negedge clk);
            hit = 1'b0; @(negedge clk);
        end
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            summary();
        end
    end

    initial begin
        logic [9:0] exp;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset code", code, 10'h000);
        check("R1 reset valid", {9'b0, code_valid}, 10'h000);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R8 R9
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].mode) begin
                frame_count(VECS[k].t, int'(VECS[k].n));
                exp = {sat63(int'(VECS[k].n)), 4'b0};
                check("R9 count code", code, exp);
            end else begin
                frame_time(VECS[k].t, int'(VECS[k].n));
                exp = {sat63(int'(VECS[k].n)), ones15(VECS[k].t)};
                check("R2 R3 R4 R5 R8 time code", code, exp);
            end
            check("R5 R9 valid", {9'b0, code_valid}, 10'h001);
        end

        // R6: stop with no hit, later hit ignored
        count_mode = 1'b0;
        clear_frame();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        check("R6 no-event code", code, 10'h000);
        check("R6 no-event valid", {9'b0, code_valid}, 10'h000);
        @(negedge clk); hit = 1'b1; taps = 16'hFFFF;
        @(negedge clk); hit = 1'b0;
        repeat (2) @(negedge clk);
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        check("R6 late hit code", code, 10'h000);
        check("R6 late hit valid", {9'b0, code_valid}, 10'h000);

        // R7: second hit with different taps does not recapture
        clear_frame();
        @(negedge clk); hit = 1'b1; taps = 16'h0007;
        @(negedge clk); hit = 1'b1; taps = 16'h7FFF;
        @(negedge clk); hit = 1'b0;
        @(negedge clk);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        check("R7 first hit only", code, {6'd4, 4'd3});

        // R11: hit and stop on the same edge
        clear_frame();
        @(negedge clk); hit = 1'b1; stop = 1'b1; taps = 16'h001F;
        @(negedge clk); hit = 1'b0; stop = 1'b0;
        check("R11 same-edge code", code, {6'd0, 4'd5});
        check("R11 same-edge valid", {9'b0, code_valid}, 10'h001);

        // R10: result held through extra stops and hits
        @(negedge clk); hit = 1'b1; taps = 16'h7FFF;
        @(negedge clk); hit = 1'b0; stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        @(negedge clk);
        check("R10 held code", code, {6'd0, 4'd5});
        check("R10 held valid", {9'b0, code_valid}, 10'h001);

        // R1: clear empties the result
        clear_frame();
        check("R1 clear code", code, 10'h000);
        check("R1 clear valid", {9'b0, code_valid}, 10'h000);

        // R9: counting mode, hit on the stop edge counts
        count_mode = 1'b1;
        clear_frame();
        @(negedge clk); hit = 1'b1;
        @(negedge clk); hit = 1'b0;
        @(negedge clk); hit = 1'b1; stop = 1'b1;
        @(negedge clk); hit = 1'b0; stop = 1'b0;
        check("R9 stop-edge hit", code, {6'd2, 4'd0});

        // R8: counting saturates
        frame_count(16'h0000, 70);
        check("R8 count saturate", code, {6'd63, 4'd0});

        done = 1'b1;
        summary();
    end
endmodule